// File: doc/BRIEF.md
# SM4/SM3 Scalar Crypto Execute Unit

This unit sits in the execute stage of a RISC-V core. It decodes a 32-bit instruction word and, when the word is one of four scalar cryptography operations, computes the destination value from two source operands. Two operations speed up the SM4 block cipher. One is a round step and one is a key-schedule step. Each takes a single byte from the second operand and passes it through the SM4 substitution box. It then applies one of two fixed linear mixing networks, rotates the mixed word back to the byte's lane and XORs it into the first operand. The other two operations are the SM3 hash permutations, each built from rotates and XORs on the low word of the first operand.

Each operation is accepted only when its extension enable is set. A word that matches nothing, or whose extension is off, is reported as illegal and produces a zero result. The result and both flags are registered. They appear one cycle after the input strobe. In 64-bit mode the 32-bit result is sign-extended; in 32-bit mode the upper half is zero. The substitution table is a 256-entry constant ROM. Its contents are computed at elaboration from the cipher's field inversion and affine map.

Top module: `sm_crypto_unit`

## Requirements
- R1: The SM4 round step is recognised when bits [29:25]=11000, bits [14:12]=000 and bits [6:0]=0110011. The key step uses the same fields with bits [29:25]=11010. In both, bits [31:30] form the byte select k, and the shift amount is 8*k.
- R2: The SM3 permutation P0 is recognised when bits [31:20]=000100001000, bits [14:12]=001 and bits [6:0]=0010011. P1 uses the same fields but with bits [24:20]=01001.
- R3: SM4 round step: let b be the SM4 S-box output for byte rs2[8k+7:8k], zero-extended to 32 bits. Compute b ^ b<<2 ^ b<<8 ^ b<<18 ^ (b&0x3F)<<26 ^ (b&0xC0)<<10. The low 32 bits of the result are rs1[31:0] XOR that value rotated left by 8k.
- R4: SM4 key step: the same as R3 but with the mix b ^ (b&0x07)<<29 ^ (b&0xFE)<<7 ^ (b&0x01)<<23 ^ (b&0xF8)<<13.
- R5: For x = rs1[31:0], P0 gives x ^ rol(x,9) ^ rol(x,17) and P1 gives x ^ rol(x,15) ^ rol(x,23).
- R6: An SM4 operation with the SM4 enable low, or an SM3 operation with the SM3 enable low, is illegal. The other enable has no effect on it.
- R7: A word matching none of the four encodings is illegal. An illegal word gives outIllegal=1 and result=0.
- R8: outValid is high exactly in the cycle after a cycle with inValid high. Without inValid, the result holds its value.
- R9: With rv64Mode=1, result bits [63:32] copy bit 31. With rv64Mode=0, they are zero.
- R10: After reset, outValid, outIllegal and result are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| inValid | input | 1 | Instruction and operands are presented this cycle |
| instr | input | 32 | Instruction word |
| rs1 | input | XLEN | First source operand |
| rs2 | input | XLEN | Second source operand |
| rv64Mode | input | 1 | 1 selects sign extension to the full width, 0 the 32-bit view |
| enSm4 | input | 1 | Enables the SM4 operations |
| enSm3 | input | 1 | Enables the SM3 operations |
| outValid | output | 1 | Result and flags are valid |
| outIllegal | output | 1 | The presented word was not accepted |
| result | output | XLEN | Destination value |

## Verification
The result is registered, so any fault in decode, byte selection, the S-box ROM or a mixing network shows on the result bus exactly one cycle after the strobe, with nothing hidden behind it. A wrong S-box entry corrupts every lane that selects that byte. To expose it, the checked bytes cover all four lanes. A decode fault shows as a flipped illegal flag, or as a result that is zero when it should not be, in the same cycle. Errors in sign extension or in holding the result show in the upper half of the result, or on idle cycles right after an operation.

// File: rtl/sm_crypto_pkg.sv
package sm_crypto_pkg;

  localparam logic [6:0] OPC_REG = 7'b0110011;
  localparam logic [6:0] OPC_IMM = 7'b0010011;
  localparam logic [4:0] SM4_RND_SEL = 5'b11000;
  localparam logic [4:0] SM4_KEY_SEL = 5'b11010;
  localparam logic [11:0] SM3_P0_CODE = 12'b0001_0000_1000;
  localparam logic [11:0] SM3_P1_CODE = 12'b0001_0000_1001;

  // Field reduction polynomial x^8+x^7+x^6+x^5+x^4+x^2+1 (low byte)
  localparam logic [7:0] FIELD_POLY = 8'hF5;
  // Affine map row seed and constant
  localparam logic [7:0] AFF_SEED = 8'hD3;

  typedef struct packed {
    logic       load;
    logic       legal;
    logic       sm4Rnd;
    logic       sm4Key;
    logic       sm3P0;
    logic       sm3P1;
    logic [1:0] byteSel;
    logic       wide;
  } smStrobes_t;

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    logic       carry;
    acc = '0;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      carry = sh[7];
      sh = {sh[6:0], 1'b0};
      if (carry) sh = sh ^ FIELD_POLY;
    end
    return acc;
  endfunction

  // Inverse as a^254; zero maps to zero
  function automatic logic [7:0] gfInv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] acc;
    sq  = a;
    acc = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gfMul(sq, sq);
      acc = gfMul(acc, sq);
    end
    return acc;
  endfunction

  function automatic logic [7:0] affineMap(input logic [7:0] x);
    logic [7:0]  y;
    logic [15:0] dbl;
    logic [7:0]  row;
    for (int i = 0; i < 8; i++) begin
      dbl = {AFF_SEED, AFF_SEED} >> i;
      row = dbl[7:0];
      y[7-i] = ^(row & x);
    end
    return y ^ AFF_SEED;
  endfunction

  function automatic logic [7:0] sboxEntry(input logic [7:0] x);
    return affineMap(gfInv(affineMap(x)));
  endfunction

  function automatic logic [31:0] rol32(input logic [31:0] x, input logic [4:0] sh);
    logic [63:0] tmp;
    tmp = {x, x} << sh;
    return tmp[63:32];
  endfunction

endpackage

// File: rtl/sm4_sbox_rom.sv
module sm4_sbox_rom
  import sm_crypto_pkg::*;
#(
  parameter int ENTRIES = 256
) (
  input  logic [7:0] addr,
  output logic [7:0] data
);
  logic [7:0] romTbl [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_rom
    localparam logic [7:0] ENTRY_VAL = sboxEntry(8'(i));
    assign romTbl[i] = ENTRY_VAL;
  end

  assign data = romTbl[addr];
endmodule

// File: rtl/sm_decode.sv
module sm_decode
  import sm_crypto_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [31:0] instr,
  input  logic       rv64Mode,
  input  logic       enSm4,
  input  logic       enSm3,
  output smStrobes_t strobes,
  output logic       outValid,
  output logic       outIllegal
);
  logic rndHit, keyHit, p0Hit, p1Hit;
  logic anyLegal;
  logic unusedFields;

  assign unusedFields = ^{instr[24:15], instr[11:7]};

  always_comb begin
    rndHit = (instr[29:25] == SM4_RND_SEL) && (instr[14:12] == 3'b000) &&
             (instr[6:0] == OPC_REG) && enSm4;
    keyHit = (instr[29:25] == SM4_KEY_SEL) && (instr[14:12] == 3'b000) &&
             (instr[6:0] == OPC_REG) && enSm4;
    p0Hit  = (instr[31:20] == SM3_P0_CODE) && (instr[14:12] == 3'b001) &&
             (instr[6:0] == OPC_IMM) && enSm3;
    p1Hit  = (instr[31:20] == SM3_P1_CODE) && (instr[14:12] == 3'b001) &&
             (instr[6:0] == OPC_IMM) && enSm3;
    anyLegal = rndHit | keyHit | p0Hit | p1Hit;
  end

  always_comb begin
    strobes.load    = inValid;
    strobes.legal   = anyLegal;
    strobes.sm4Rnd  = rndHit;
    strobes.sm4Key  = keyHit;
    strobes.sm3P0   = p0Hit;
    strobes.sm3P1   = p1Hit;
    strobes.byteSel = instr[31:30];
    strobes.wide    = rv64Mode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outIllegal <= 1'b0;
    end else begin
      outValid   <= inValid;
      outIllegal <= inValid & ~anyLegal;
    end
  end

  // R1
  one_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.sm4Rnd, strobes.sm4Key, strobes.sm3P0, strobes.sm3P1}));

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R6
  sm4_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !enSm4 && instr[6:0] == OPC_REG && instr[14:12] == 3'b000 &&
     (instr[29:25] == SM4_RND_SEL || instr[29:25] == SM4_KEY_SEL)) |=> outIllegal);

  // R7
  illegal_in_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outIllegal |-> outValid);
endmodule

// File: rtl/sm_datapath.sv
module sm_datapath
  import sm_crypto_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  smStrobes_t      strobes,
  input  logic [31:0]     srcA,
  input  logic [31:0]     srcB,
  output logic [XLEN-1:0] resultQ
);
  localparam int WORD = 32;

  logic [4:0]      shamt;
  logic [7:0]      pickedByte;
  logic [7:0]      subByte;
  logic [WORD-1:0] b;
  logic [WORD-1:0] rndMix, keyMix, mixSel, mixRot;
  logic [WORD-1:0] sm3Val, low32;
  logic [XLEN-1:0] extended;

  assign shamt = {strobes.byteSel, 3'b000};

  always_comb begin
    logic [WORD-1:0] shifted;
    shifted    = srcB >> shamt;
    pickedByte = shifted[7:0];
  end

  sm4_sbox_rom u_rom (
    .addr(pickedByte),
    .data(subByte)
  );

  assign b = {24'h0, subByte};

  always_comb begin
    rndMix = b ^ (b << 2) ^ (b << 8) ^ (b << 18) ^
             ((b & 32'h0000_003F) << 26) ^ ((b & 32'h0000_00C0) << 10);
    keyMix = b ^ ((b & 32'h0000_0007) << 29) ^ ((b & 32'h0000_00FE) << 7) ^
             ((b & 32'h0000_0001) << 23) ^ ((b & 32'h0000_00F8) << 13);
    mixSel = strobes.sm4Rnd ? rndMix : keyMix;
    mixRot = rol32(mixSel, shamt);
  end

  always_comb begin
    if (strobes.sm3P0)
      sm3Val = srcA ^ rol32(srcA, 5'd9) ^ rol32(srcA, 5'd17);
    else
      sm3Val = srcA ^ rol32(srcA, 5'd15) ^ rol32(srcA, 5'd23);
  end

  always_comb begin
    if (!strobes.legal)
      low32 = '0;
    else if (strobes.sm4Rnd || strobes.sm4Key)
      low32 = mixRot ^ srcA;
    else
      low32 = sm3Val;
  end

  if (XLEN > WORD) begin : g_ext
    localparam int UPPER = XLEN - WORD;
    always_comb begin
      if (strobes.wide) extended = {{UPPER{low32[WORD-1]}}, low32};
      else              extended = {{UPPER{1'b0}}, low32};
    end

    // R9
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.load && !strobes.wide) |=> (resultQ[XLEN-1:WORD] == '0));
  end else begin : g_noext
    logic unusedWide;
    assign unusedWide = strobes.wide;
    assign extended = low32;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              resultQ <= '0;
    else if (strobes.load)  resultQ <= extended;
  end

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(resultQ));
endmodule

// File: rtl/sm_crypto_unit.sv
module sm_crypto_unit
  import sm_crypto_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1,
  input  logic [XLEN-1:0] rs2,
  input  logic            rv64Mode,
  input  logic            enSm4,
  input  logic            enSm3,
  output logic            outValid,
  output logic            outIllegal,
  output logic [XLEN-1:0] result
);
  smStrobes_t strobes;

  if (XLEN > 32) begin : g_sink
    logic unusedHigh;
    assign unusedHigh = ^{rs1[XLEN-1:32], rs2[XLEN-1:32]};

    // R9
    sign_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && rv64Mode) |=> (result[XLEN-1:32] == {(XLEN-32){result[31]}}));
  end

  sm_decode u_dec (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .instr     (instr),
    .rv64Mode  (rv64Mode),
    .enSm4     (enSm4),
    .enSm3     (enSm3),
    .strobes   (strobes),
    .outValid  (outValid),
    .outIllegal(outIllegal)
  );

  sm_datapath #(.XLEN(XLEN)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .srcA   (rs1[31:0]),
    .srcB   (rs2[31:0]),
    .resultQ(result)
  );

  // R7
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    outIllegal |-> (result == '0));
endmodule

// File: tb/sim_sm_crypto_unit.sv
module sim_sm_crypto_unit;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            inValid = 1'b0;
  logic [31:0]     instr = '0;
  logic [XLEN-1:0] rs1 = '0;
  logic [XLEN-1:0] rs2 = '0;
  logic            rv64Mode = 1'b1;
  logic            enSm4 = 1'b1;
  logic            enSm3 = 1'b1;
  logic            outValid, outIllegal;
  logic [XLEN-1:0] result;

  int nCmp = 0;
  int nBad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sm_crypto_unit #(.XLEN(XLEN)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
    .rs1(rs1), .rs2(rs2), .rv64Mode(rv64Mode), .enSm4(enSm4), .enSm3(enSm3),
    .outValid(outValid), .outIllegal(outIllegal), .result(result)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // Published SM4 S-box values for the bytes the bench uses
  function automatic logic [7:0] knownSub(input logic [7:0] v);
    case (v)
      8'h00: return 8'hD6;
      8'h01: return 8'h90;
      8'h02: return 8'hE9;
      8'h03: return 8'hFE;
      8'h05: return 8'hE1;
      8'h0A: return 8'h14;
      8'h0F: return 8'h05;
      8'h10: return 8'h2B;
      8'h13: return 8'h76;
      8'hFF: return 8'h48;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    if (n == 0) return x;
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [63:0] widen(input logic [31:0] v, input bit w);
    return w ? {{32{v[31]}}, v} : {32'h0, v};
  endfunction

  function automatic logic [31:0] refSm4(input bit keyStep, input logic [31:0] a,
                                         input logic [31:0] bw, input int k);
    logic [31:0] s, m;
    s = {24'h0, knownSub(bw[8*k +: 8])};
    if (!keyStep)
      m = s ^ (s << 2) ^ (s << 8) ^ (s << 18) ^ ((s & 32'h3F) << 26) ^ ((s & 32'hC0) << 10);
    else
      m = s ^ ((s & 32'h07) << 29) ^ ((s & 32'hFE) << 7) ^ ((s & 32'h01) << 23) ^ ((s & 32'hF8) << 13);
    return rotl(m, 8 * k) ^ a;
  endfunction

  function automatic logic [31:0] encSm4(input bit keyStep, input logic [1:0] k);
    return {k, keyStep ? 5'b11010 : 5'b11000, 5'd7, 5'd3, 3'b000, 5'd9, 7'b0110011};
  endfunction

  function automatic logic [31:0] encSm3(input bit p1);
    return {7'b0001000, p1 ? 5'b01001 : 5'b01000, 5'd4, 3'b001, 5'd11, 7'b0010011};
  endfunction

  task automatic issue(input logic [31:0] w, input logic [63:0] a, input logic [63:0] bv,
                       input bit wide, input bit e4, input bit e3);
    @(negedge clk);
    instr = w; rs1 = a; rs2 = bv; rv64Mode = wide; enSm4 = e4; enSm3 = e3;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 valid", {63'h0, outValid}, 64'h0);
    check("R10 illegal", {63'h0, outIllegal}, 64'h0);
    check("R10 result", result, 64'h0);
    rstN = 1'b1;
  endtask

  task automatic tSm4(input bit keyStep);
    logic [31:0] bvs [2];
    logic [31:0] avs [2];
    bvs[0] = 32'h13FF0501; bvs[1] = 32'h100A000F;
    avs[0] = 32'h0123ABCD; avs[1] = 32'hF00DBEEF;
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 4; k++) begin
        issue(encSm4(keyStep, 2'(k)), {32'hDEADBEEF, avs[p]}, {32'hCAFEF00D, bvs[p]}, 1'b1, 1'b1, 1'b0);
        check(keyStep ? "R4 R1 R9 key result" : "R3 R1 R9 round result", result,
              widen(refSm4(keyStep, avs[p], bvs[p], k), 1'b1));
        check("R8 R1 valid", {62'h0, outValid, outIllegal}, 64'h2);
      end
    end
  endtask

  task automatic tSm3();
    logic [31:0] xs [3];
    xs[0] = 32'h00000001; xs[1] = 32'h80000000; xs[2] = 32'h12345678;
    for (int i = 0; i < 3; i++) begin
      issue(encSm3(1'b0), {32'h55555555, xs[i]}, 64'h0, 1'b1, 1'b0, 1'b1);
      check("R5 R2 R9 p0", result, widen(xs[i] ^ rotl(xs[i], 9) ^ rotl(xs[i], 17), 1'b1));
      check("R2 p0 legal", {62'h0, outValid, outIllegal}, 64'h2);
      issue(encSm3(1'b1), {32'h55555555, xs[i]}, 64'h0, 1'b1, 1'b0, 1'b1);
      check("R5 R2 R9 p1", result, widen(xs[i] ^ rotl(xs[i], 15) ^ rotl(xs[i], 23), 1'b1));
    end
  endtask

  task automatic tEnables();
    issue(encSm4(1'b0, 2'd0), 64'h1, 64'h2, 1'b1, 1'b0, 1'b1);
    check("R6 sm4 off illegal", {62'h0, outValid, outIllegal}, 64'h3);
    check("R6 sm4 off zero", result, 64'h0);
    issue(encSm4(1'b1, 2'd1), 64'h1, 64'h0200, 1'b1, 1'b0, 1'b1);
    check("R6 key off illegal", {63'h0, outIllegal}, 64'h1);
    issue(encSm3(1'b0), 64'h7, 64'h0, 1'b1, 1'b1, 1'b0);
    check("R6 sm3 off illegal", {62'h0, outValid, outIllegal}, 64'h3);
    check("R6 sm3 off zero", result, 64'h0);
    issue(encSm3(1'b1), 64'h3, 64'h0, 1'b1, 1'b0, 1'b1);
    check("R6 sm4 enable no effect on sm3", result, widen(32'h3 ^ rotl(32'h3, 15) ^ rotl(32'h3, 23), 1'b1));
  endtask

  task automatic tUnknown();
    logic [31:0] bad [4];
    bad[0] = encSm4(1'b0, 2'd2) | 32'h0000_1000;
    bad[1] = {2'b00, 5'b11001, 5'd1, 5'd2, 3'b000, 5'd3, 7'b0110011};
    bad[2] = {7'b0001000, 5'b01010, 5'd4, 3'b001, 5'd5, 7'b0010011};
    bad[3] = encSm3(1'b0) ^ 32'h0000_0040;
    for (int i = 0; i < 4; i++) begin
      issue(bad[i], 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0005_0000, 1'b1, 1'b1, 1'b1);
      check("R7 unknown illegal", {62'h0, outValid, outIllegal}, 64'h3);
      check("R7 unknown zero", result, 64'h0);
    end
  endtask

  task automatic tHold();
    logic [63:0] expd;
    issue(encSm3(1'b0), 64'h0000_0000_8000_0001, 64'h0, 1'b1, 1'b1, 1'b1);
    expd = widen(32'h80000001 ^ rotl(32'h80000001, 9) ^ rotl(32'h80000001, 17), 1'b1);
    check("R8 fresh", result, expd);
    rs1 = 64'h1234; instr = encSm3(1'b1);
    repeat (3) begin
      @(negedge clk);
      check("R8 idle valid low", {63'h0, outValid}, 64'h0);
      check("R8 idle hold", result, expd);
    end
  endtask

  task automatic tRv32();
    issue(encSm3(1'b0), 64'h0000_0000_8000_0000, 64'h0, 1'b0, 1'b1, 1'b1);
    check("R9 narrow p0", result, widen(32'h80000000 ^ rotl(32'h80000000, 9) ^ rotl(32'h80000000, 17), 1'b0));
    issue(encSm4(1'b0, 2'd3), 64'h0000_0000_FFFF_FFFF, 64'h1300_0000, 1'b0, 1'b1, 1'b1);
    check("R9 R3 narrow round", result, widen(refSm4(1'b0, 32'hFFFFFFFF, 32'h13000000, 3), 1'b0));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog expired, got running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    tReset();
    tSm4(1'b0);
    tSm4(1'b1);
    tSm3();
    tEnables();
    tUnknown();
    tHold();
    tRv32();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule